// File: doc/BRIEF.md
# Motor Run-State Supervisor

This block decides whether a fan motor's power stage may drive. After reset it rests in a low-power standby state with the reference supply switched off. A high pulse on the filtered speed-command input that lasts longer than one microsecond wakes it into a startup state. From startup, a request from the startup sequencer moves it to normal running.

While the motor is starting or running, the block watches for speed edges from the position detector. If none arrives within a programmable window, the rotor is treated as stalled. The drive is then switched off for a fixed off-time, after which a new startup is attempted without outside help. If the command input stays low for longer than that same off-time, the block falls back to standby from any active state.

The states, with their 2-bit codes, are STANDBY (0), STARTUP (1), RUN (2) and LOCKED_OFF (3). The transitions are named as follows. WAKE goes STANDBY→STARTUP. PROMOTE goes STARTUP→RUN. STALL goes from STARTUP or RUN to LOCKED_OFF. RETRY goes LOCKED_OFF→STARTUP. SLEEP goes from STARTUP, RUN or LOCKED_OFF to STANDBY. All time limits are counted in clock cycles. The wake limit is `CLK_HZ/1_000_000` cycles.

Top module: `run_supervisor`

## Requirements
- R1: While reset is asserted and just after it is released, `state_code` is 0 (STANDBY), and `drive_en` and `vref_en` are both 0.
- R2: In STANDBY, `pwm_lvl` must be high for WAKE_CYC+1 consecutive cycles (WAKE_CYC = CLK_HZ/1e6) before the state becomes 1 (STARTUP) at the next edge. A high run of exactly WAKE_CYC cycles leaves the state at 0.
- R3: In STARTUP, a `run_req` cycle moves the state to 2 (RUN) at the next edge, unless a higher-priority transition applies in that cycle.
- R4: In STARTUP or RUN, LOCK_CYC consecutive cycles with no `speed_edge` move the state to 3 (LOCKED_OFF). Every `speed_edge` restarts that window, and the window keeps running across PROMOTE. RUN never goes directly to STARTUP.
- R5: LOCKED_OFF lasts exactly OFF_CYC cycles and then always goes to 1 (STARTUP). It never goes to RUN, and `run_req` is ignored there.
- R6: In any state other than STANDBY, `pwm_lvl` held low for OFF_CYC+1 consecutive cycles moves the state to 0. A low run of OFF_CYC cycles does not. The state never enters STANDBY in a cycle that follows a high `pwm_lvl`.
- R7: Priority within one cycle is SLEEP first, then STALL, then PROMOTE. A stall that coincides with `run_req` leads to state 3, not 2.
- R8: `drive_en` is 1 exactly in states 1 and 2.
- R9: `vref_en` is 0 exactly in state 0.
- R10: In STANDBY, `speed_edge` and `run_req` have no effect. The state stays 0 unless the wake pulse of R2 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 1 | Filtered level of the speed-command input |
| speed_edge | input | 1 | One-cycle pulse per detected speed edge |
| run_req | input | 1 | Startup sequencer requests normal running |
| drive_en | output | 1 | Power stage may switch |
| vref_en | output | 1 | Reference supply enable |
| state_code | output | 2 | 0 STANDBY, 1 STARTUP, 2 RUN, 3 LOCKED_OFF |

## Verification
All three outputs are decoded from the state register, so a wrong state shows on `state_code` in the same cycle it is taken. It also flips `drive_en` or `vref_en` whenever the wrong state sits in a different enable class. A counter that is off by one changes the cycle in which a WAKE, STALL, RETRY or SLEEP shows up. The bench therefore compares every cycle against a cycle-accurate model, and it places pulses exactly at the wake, lock and off-time limits so that an off-by-one error is visible one cycle early or late.

// File: rtl/run_sup_pkg.sv
package run_sup_pkg;
    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_STARTUP = 2'd1,
        ST_RUN     = 2'd2,
        ST_LOCKOFF = 2'd3
    } sup_state_t;
endpackage

// File: rtl/run_sup_timer.sv
// Consecutive-cycle detector: hit is high in the LIMIT-th consecutive enabled cycle and after.
module run_sup_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!en)        cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end

    assign hit = en && (cnt == TOP);
endmodule

// File: rtl/run_sup_fsm.sv
module run_sup_fsm
    import run_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wake_hit,
    input  logic       low_hit,
    input  logic       lock_hit,
    input  logic       off_hit,
    input  logic       run_req,
    output sup_state_t state
);
    sup_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_STANDBY: if (wake_hit) nxt = ST_STARTUP;
            ST_STARTUP: begin
                if (low_hit)       nxt = ST_STANDBY;
                else if (lock_hit) nxt = ST_LOCKOFF;
                else if (run_req)  nxt = ST_RUN;
            end
            ST_RUN: begin
                if (low_hit)       nxt = ST_STANDBY;
                else if (lock_hit) nxt = ST_LOCKOFF;
            end
            ST_LOCKOFF: begin
                if (low_hit)       nxt = ST_STANDBY;
                else if (off_hit)  nxt = ST_STARTUP;
            end
            default:               nxt = ST_STANDBY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STANDBY;
        else        state <= nxt;
    end
endmodule

// File: rtl/run_supervisor.sv
module run_supervisor
    import run_sup_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int LOCK_CYC = 200_000,
    parameter int OFF_CYC  = 500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwm_lvl,
    input  logic       speed_edge,
    input  logic       run_req,
    output logic       drive_en,
    output logic       vref_en,
    output logic [1:0] state_code
);
    localparam int WAKE_CYC = CLK_HZ / 1_000_000;

    sup_state_t state;
    logic wake_hit, low_hit, lock_hit, off_hit;
    logic active;

    assign active = (state == ST_STARTUP) || (state == ST_RUN);

    run_sup_timer #(.LIMIT(WAKE_CYC + 1)) u_wake (
        .clk(clk), .rst_n(rst_n),
        .en(pwm_lvl && (state == ST_STANDBY)), .hit(wake_hit));

    run_sup_timer #(.LIMIT(OFF_CYC + 1)) u_low (
        .clk(clk), .rst_n(rst_n),
        .en(!pwm_lvl && (state != ST_STANDBY)), .hit(low_hit));

    run_sup_timer #(.LIMIT(LOCK_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .en(active && !speed_edge), .hit(lock_hit));

    run_sup_timer #(.LIMIT(OFF_CYC)) u_off (
        .clk(clk), .rst_n(rst_n),
        .en(state == ST_LOCKOFF), .hit(off_hit));

    run_sup_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wake_hit(wake_hit), .low_hit(low_hit),
        .lock_hit(lock_hit), .off_hit(off_hit),
        .run_req(run_req), .state(state));

    always_comb begin
        drive_en   = 1'b0;
        vref_en    = 1'b1;
        state_code = state;
        unique case (state)
            ST_STANDBY: vref_en  = 1'b0;
            ST_STARTUP: drive_en = 1'b1;
            ST_RUN:     drive_en = 1'b1;
            ST_LOCKOFF: drive_en = 1'b0;
            default:    vref_en  = 1'b0;
        endcase
    end
endmodule

// File: rtl/run_supervisor_chk.sv
module run_supervisor_chk #(
    parameter int OFF_CYC = 500_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_lvl,
    input logic       drive_en,
    input logic       vref_en,
    input logic [1:0] state_code
);
    int unsigned off_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 off_seen <= 0;
        else if (state_code == 2'd3) off_seen <= off_seen + 1;
        else                        off_seen <= 0;
    end

    // R1
    always @(negedge clk) if (!rst_n) begin
        reset_state_chk: assert (state_code == 2'd0 && !drive_en && !vref_en);
    end

    // R2
    wake_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd0 && !pwm_lvl) |=> state_code == 2'd0);

    // R10
    standby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd0) |=> (state_code == 2'd0 || state_code == 2'd1));

    // R4
    run_no_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd2) |=> state_code != 2'd1);

    // R5
    lockoff_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd3) |=> state_code != 2'd2);

    // R5
    lockoff_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd3) |-> off_seen < OFF_CYC);

    // R6
    sleep_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'd0 && pwm_lvl) |=> state_code != 2'd0);

    // R9
    standby_vref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'd0) |-> !vref_en);

    // R8
    drive_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> ($past(state_code) == 2'd0 || $past(state_code) == 2'd3));
endmodule

bind run_supervisor run_supervisor_chk #(.OFF_CYC(OFF_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl),
    .drive_en(drive_en), .vref_en(vref_en), .state_code(state_code));

// File: tb/tb_run_supervisor.sv
`timescale 1ns/1ps
module tb_run_supervisor;
    localparam int CLK_HZ = 100_000_000;
    localparam int WAKE   = CLK_HZ / 1_000_000;
    localparam int LOCK   = 150;
    localparam int OFF    = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_lvl = 1'b0, speed_edge = 1'b0, run_req = 1'b0;
    logic drive_en, vref_en;
    logic [1:0] state_code;

    int vectors = 0, errors = 0, cyc = 0;
    bit done = 0;

    // model state
    int m_st = 0, hi_run = 0, lo_run = 0, nl_run = 0, off_run = 0;
    string m_why = "R1";

    always #5 clk = ~clk;

    run_supervisor #(.CLK_HZ(CLK_HZ), .LOCK_CYC(LOCK), .OFF_CYC(OFF)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .speed_edge(speed_edge),
        .run_req(run_req), .drive_en(drive_en), .vref_en(vref_en),
        .state_code(state_code));

    function automatic int sup_next(input int st, input bit wake, input bit lowx,
                                    input bit lock, input bit offd, input bit rq,
                                    output string why);
        why = "R10";
        case (st)
            0: begin if (wake) begin why = "R2"; return 1; end return 0; end
            1: begin
                if (lowx) begin why = lock ? "R7" : "R6"; return 0; end
                if (lock) begin why = rq ? "R7" : "R4"; return 3; end
                if (rq)   begin why = "R3"; return 2; end
                why = "R3"; return 1;
            end
            2: begin
                if (lowx) begin why = "R6"; return 0; end
                if (lock) begin why = "R4"; return 3; end
                why = "R4"; return 2;
            end
            default: begin
                if (lowx) begin why = "R6"; return 0; end
                why = "R5";
                return offd ? 1 : 3;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; hi_run = 0; lo_run = 0; nl_run = 0; off_run = 0; m_why = "R1";
        end else begin
            string w;
            hi_run  = (m_st == 0 && pwm_lvl) ? hi_run + 1 : 0;
            lo_run  = (m_st != 0 && !pwm_lvl) ? lo_run + 1 : 0;
            nl_run  = ((m_st == 1 || m_st == 2) && !speed_edge) ? nl_run + 1 : 0;
            off_run = (m_st == 3) ? off_run + 1 : 0;
            m_st = sup_next(m_st, hi_run > WAKE, lo_run > OFF, nl_run >= LOCK,
                            off_run >= OFF, run_req, w);
            m_why = w;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic compare();
        chk(state_code == 2'(m_st), m_why, state_code, m_st);
        chk(drive_en == (m_st == 1 || m_st == 2), "R8", drive_en, (m_st == 1 || m_st == 2));
        chk(vref_en == (m_st != 0), "R9", vref_en, (m_st != 0));
    endtask

    task automatic step(input bit p, input bit e, input bit r);
        pwm_lvl = p; speed_edge = e; run_req = r;
        @(negedge clk);
        compare();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150_000 && !done) begin
            errors++;
            $display("FAIL watchdog R1..: actual=%0d expected<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h0005_EED1;
        int low_left = 0;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        compare();
        chk(state_code == 2'd0 && !drive_en && !vref_en, "R1", state_code, 0);
        rst_n = 1'b1;
        step(0, 0, 0);
        chk(state_code == 2'd0, "R1", state_code, 0);

        // exactly WAKE cycles high: no wake
        repeat (WAKE) step(1, 0, 0);
        step(0, 0, 0);
        chk(state_code == 2'd0, "R2", state_code, 0);
        // WAKE+1 cycles high: wake
        repeat (WAKE + 1) step(1, 0, 0);
        chk(state_code == 2'd1, "R2", state_code, 1);

        // edges keep it alive, request promotes
        for (int i = 0; i < 200; i++) step(1, (i % 40) == 0, i == 60);
        chk(state_code == 2'd2, "R3", state_code, 2);

        // edges stop: stall
        repeat (LOCK + 10) step(1, 0, 0);
        chk(state_code == 2'd3, "R4", state_code, 3);

        // run_req held during off-time, must retry into STARTUP
        while (state_code == 2'd3) step(1, 0, 1);
        chk(state_code == 2'd1, "R5", state_code, 1);

        // stall coincides with run_req
        repeat (LOCK - 1) step(1, 0, 0);
        step(1, 0, 1);
        chk(state_code == 2'd3, "R7", state_code, 3);

        // low run of OFF cycles keeps state, OFF+1 sleeps
        repeat (OFF) step(0, 0, 0);
        chk(state_code != 2'd0, "R6", state_code, 1);
        step(0, 0, 0);
        chk(state_code == 2'd0, "R6", state_code, 0);

        // standby ignores edges and requests
        repeat (50) step(0, 1, 1);
        chk(state_code == 2'd0, "R10", state_code, 0);

        // constrained random against the model
        for (int i = 0; i < 6000; i++) begin
            bit p, e, r;
            if (low_left > 0) begin p = 0; low_left--; end
            else begin
                p = 1;
                if ($urandom % 150 == 0) low_left = int'($urandom % 400) + 1;
            end
            e = ((i / 700) % 2 == 0) ? ($urandom % 30 == 0) : 1'b0;
            r = ($urandom % 25 == 0);
            step(p, e, r);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule